// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Operand Bypass Control

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Registers are read in decode and written in writeback, so an instruction in decode may need a value that an older instruction further down the pipe has not yet written. The block compares the two source register numbers of the decoding instruction against the destination numbers and write-enable flags held in the three downstream pipeline registers. It then either stalls the front of the pipe or tells the datapath where to pick up the newer value.

A stall holds the PC and the decode register and puts a bubble into the decode-to-execute register. The bubble is made by zeroing the register-write and memory-write controls passed to that register. A compile-time parameter selects one of two modes. In interlock-only mode the block stalls on any match with the three downstream stages. In forwarding mode it stalls only when the instruction in execute is a load that feeds the decoding instruction. For every other dependency it gives per-operand execute forwarding selects and a register-file write-through select. The execute selects are worked out in decode and registered, so they arrive in execute together with the operands they steer.

Top module: `hz_interlock`

## Requirements
- R1: Source register number 0 never matches any stage, never causes a stall and never raises a register-file bypass, whatever the downstream destinations are.
- R2: A downstream stage whose write-enable is low never matches, even if its destination number equals a decode source.
- R3: In interlock-only mode (`FWD_EN`=0), `stall` is high in the same cycle whenever a nonzero decode source equals the destination of the decode-to-execute, execute-to-memory or memory-to-writeback register and that stage's write-enable is high.
- R4: In forwarding mode (`FWD_EN`=1), `stall` is high only when `idex_is_load` and `idex_we` are high and `idex_rd` equals a nonzero decode source. If the pipe advances around it, the stall lasts exactly one cycle.
- R5: While `stall` is high, `idex_wr_en_d` and `idex_st_en_d` are 0. Otherwise they equal `dec_wr_en` and `dec_st_en`.
- R6: The execute selects `ex_fwd_a`/`ex_fwd_b` are registered and take effect one clock after decode. Encoding: 0 = register-file value, 1 = execute-to-memory result, 2 = memory-to-writeback result. A producer in decode-to-execute at decode time gives 1, and a producer in execute-to-memory gives 2. Both selects are 0 during reset.
- R7: When producers in both decode-to-execute and execute-to-memory match one source, the newer one (decode-to-execute, select 1) wins.
- R8: In forwarding mode, `rf_byp_a`/`rf_byp_b` are high when the memory-to-writeback stage is writing the matching nonzero source in the same cycle. In interlock-only mode they stay 0.
- R9: In the cycle after a stall, both execute selects are 0 (a bubble is in execute). In interlock-only mode they are always 0.
- R10: For the sequence `add r3,r1,r2` then `sub r5,r3,r5` with the pipe otherwise empty, interlock-only mode stalls for exactly three cycles and forwarding mode for none, with `ex_fwd_a`=1 when the `sub` reaches execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_rs_a | input | 5 | First source register of the decoding instruction |
| dec_rs_b | input | 5 | Second source register of the decoding instruction |
| dec_wr_en | input | 1 | Register-write control produced by decode |
| dec_st_en | input | 1 | Memory-write control produced by decode |
| idex_rd | input | 5 | Destination held in decode-to-execute register |
| idex_we | input | 1 | Write-enable held in decode-to-execute register |
| idex_is_load | input | 1 | Instruction in execute is a load |
| exmem_rd | input | 5 | Destination held in execute-to-memory register |
| exmem_we | input | 1 | Write-enable held in execute-to-memory register |
| memwb_rd | input | 5 | Destination held in memory-to-writeback register |
| memwb_we | input | 1 | Write-enable held in memory-to-writeback register |
| stall | output | 1 | Hold PC and decode register, bubble into execute |
| idex_wr_en_d | output | 1 | Register-write control to load into decode-to-execute |
| idex_st_en_d | output | 1 | Memory-write control to load into decode-to-execute |
| rf_byp_a | output | 1 | Register-file write-through select, first read port |
| rf_byp_b | output | 1 | Register-file write-through select, second read port |
| ex_fwd_a | output | 2 | Execute forwarding select, first ALU operand |
| ex_fwd_b | output | 2 | Execute forwarding select, second ALU operand |

## Verification
The hardest situation to reach is one where a stall and the selects registered around it interact over several cycles. An example is a load-use stall that must release after one cycle and then turn into a memory-to-writeback select. Another is a dependency that must keep the interlock-only variant stalled for exactly three cycles while the producer drains. These depend on the pipeline registers moving in response to `stall`, so the bench runs a small behavioural pipeline. It feeds short instruction sequences into both variants, advances or bubbles the stage registers according to each one's own stall output, and logs stall and select values cycle by cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Execute-stage operand source, as seen by the ALU input muxes.
  typedef enum logic [1:0] {
    FWD_REGF  = 2'd0,
    FWD_EXMEM = 2'd1,
    FWD_MEMWB = 2'd2
  } fwd_sel_e;

  localparam int unsigned REG_AW_DEF = 5;
  localparam int unsigned NSRC       = 2;

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] idex_rd,
  input  logic              idex_we,
  input  logic [REG_AW-1:0] exmem_rd,
  input  logic              exmem_we,
  input  logic [REG_AW-1:0] memwb_rd,
  input  logic              memwb_we,
  output logic              hit_idex,
  output logic              hit_exmem,
  output logic              hit_memwb
);

  logic src_live;

  // Register zero is hardwired and never carries a dependency.
  always_comb begin
    src_live  = |src;
    hit_idex  = src_live && idex_we  && (idex_rd  == src);
    hit_exmem = src_live && exmem_we && (exmem_rd == src);
    hit_memwb = src_live && memwb_we && (memwb_rd == src);
  end

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl #(
  parameter int unsigned NSRC   = 2,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic [NSRC-1:0] hit_idex,
  input  logic [NSRC-1:0] hit_exmem,
  input  logic [NSRC-1:0] hit_memwb,
  input  logic            idex_is_load,
  input  logic            dec_wr_en,
  input  logic            dec_st_en,
  output logic            stall,
  output logic            idex_wr_en_d,
  output logic            idex_st_en_d
);

  logic load_use;
  logic any_dep;

  always_comb begin
    load_use = idex_is_load && (|hit_idex);
    any_dep  = (|hit_idex) || (|hit_exmem) || (|hit_memwb);
    stall    = FWD_EN ? load_use : any_dep;
    // Bubble: the held instruction must not write anything when it is
    // duplicated into execute.
    idex_wr_en_d = dec_wr_en && !stall;
    idex_st_en_d = dec_st_en && !stall;
  end

endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter bit FWD_EN = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stall,
  input  logic     hit_idex,
  input  logic     hit_exmem,
  input  logic     hit_memwb,
  output fwd_sel_e sel_q,
  output logic     rf_byp
);

  fwd_sel_e sel_d;
  logic     sel_en;

  // Decode-time choice of the operand source the instruction will need
  // one cycle later in execute. The newest producer wins.
  always_comb begin
    sel_en = 1'b1;
    sel_d  = FWD_REGF;
    if (FWD_EN && !stall) begin
      if (hit_idex) begin
        sel_d = FWD_EXMEM;
      end else if (hit_exmem) begin
        sel_d = FWD_MEMWB;
      end
    end
    rf_byp = FWD_EN && hit_memwb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= FWD_REGF;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = REG_AW_DEF,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] dec_rs_a,
  input  logic [REG_AW-1:0] dec_rs_b,
  input  logic              dec_wr_en,
  input  logic              dec_st_en,
  input  logic [REG_AW-1:0] idex_rd,
  input  logic              idex_we,
  input  logic              idex_is_load,
  input  logic [REG_AW-1:0] exmem_rd,
  input  logic              exmem_we,
  input  logic [REG_AW-1:0] memwb_rd,
  input  logic              memwb_we,
  output logic              stall,
  output logic              idex_wr_en_d,
  output logic              idex_st_en_d,
  output logic              rf_byp_a,
  output logic              rf_byp_b,
  output logic [1:0]        ex_fwd_a,
  output logic [1:0]        ex_fwd_b
);

  logic [REG_AW-1:0] src     [NSRC];
  logic [NSRC-1:0]   h_idex;
  logic [NSRC-1:0]   h_exmem;
  logic [NSRC-1:0]   h_memwb;
  logic [NSRC-1:0]   byp;
  fwd_sel_e          sel     [NSRC];

  always_comb begin
    src[0] = dec_rs_a;
    src[1] = dec_rs_b;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_port
    hz_src_match #(.REG_AW(REG_AW)) u_match (
      .src       (src[g]),
      .idex_rd   (idex_rd),
      .idex_we   (idex_we),
      .exmem_rd  (exmem_rd),
      .exmem_we  (exmem_we),
      .memwb_rd  (memwb_rd),
      .memwb_we  (memwb_we),
      .hit_idex  (h_idex[g]),
      .hit_exmem (h_exmem[g]),
      .hit_memwb (h_memwb[g])
    );

    hz_fwd_sel #(.FWD_EN(FWD_EN)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .stall     (stall),
      .hit_idex  (h_idex[g]),
      .hit_exmem (h_exmem[g]),
      .hit_memwb (h_memwb[g]),
      .sel_q     (sel[g]),
      .rf_byp    (byp[g])
    );
  end

  hz_stall_ctrl #(.NSRC(NSRC), .FWD_EN(FWD_EN)) u_stall (
    .hit_idex     (h_idex),
    .hit_exmem    (h_exmem),
    .hit_memwb    (h_memwb),
    .idex_is_load (idex_is_load),
    .dec_wr_en    (dec_wr_en),
    .dec_st_en    (dec_st_en),
    .stall        (stall),
    .idex_wr_en_d (idex_wr_en_d),
    .idex_st_en_d (idex_st_en_d)
  );

  always_comb begin
    rf_byp_a = byp[0];
    rf_byp_b = byp[1];
    ex_fwd_a = sel[0];
    ex_fwd_b = sel[1];
  end

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
  parameter int unsigned REG_AW = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] dec_rs_a,
  input logic [REG_AW-1:0] dec_rs_b,
  input logic              idex_we,
  input logic [REG_AW-1:0] idex_rd,
  input logic              idex_is_load,
  input logic              exmem_we,
  input logic              memwb_we,
  input logic              stall,
  input logic              idex_wr_en_d,
  input logic              idex_st_en_d,
  input logic              rf_byp_a,
  input logic              rf_byp_b,
  input logic [1:0]        ex_fwd_a,
  input logic [1:0]        ex_fwd_b
);

  p_zero_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rs_a == '0 && dec_rs_b == '0) |-> (!stall && !rf_byp_a && !rf_byp_b));

  p_no_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!idex_we && !exmem_we && !memwb_we) |-> (!stall && !rf_byp_a && !rf_byp_b));

  p_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!idex_wr_en_d && !idex_st_en_d));

  p_sel_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_a != 2'd3) && (ex_fwd_b != 2'd3));

  p_after_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (ex_fwd_a == 2'd0 && ex_fwd_b == 2'd0));

  if (FWD_EN) begin : g_fwd
    p_load_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (idex_is_load && idex_we));
  end else begin : g_lock
    p_idex_dep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (idex_we && dec_rs_a != '0 && idex_rd == dec_rs_a) |-> stall);
    p_no_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_fwd_a == 2'd0 && ex_fwd_b == 2'd0 && !rf_byp_a && !rf_byp_b));
  end

endmodule

bind hz_interlock hz_interlock_chk #(.REG_AW(REG_AW), .FWD_EN(FWD_EN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_rs_a     (dec_rs_a),
  .dec_rs_b     (dec_rs_b),
  .idex_we      (idex_we),
  .idex_rd      (idex_rd),
  .idex_is_load (idex_is_load),
  .exmem_we     (exmem_we),
  .memwb_we     (memwb_we),
  .stall        (stall),
  .idex_wr_en_d (idex_wr_en_d),
  .idex_st_en_d (idex_st_en_d),
  .rf_byp_a     (rf_byp_a),
  .rf_byp_b     (rf_byp_b),
  .ex_fwd_a     (ex_fwd_a),
  .ex_fwd_b     (ex_fwd_b)
);

// File: tb/tb_hz_interlock.sv
`timescale 1ns/100ps
module tb_hz_interlock;

  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_err;

  // Index 1: forwarding variant (dut), index 0: interlock-only (dut_so).
  logic [4:0] rs_a [2];
  logic [4:0] rs_b [2];
  logic       dwe  [2];
  logic       dst  [2];
  logic [4:0] ix_rd[2];
  logic       ix_we[2];
  logic       ix_ld[2];
  logic [4:0] em_rd[2];
  logic       em_we[2];
  logic [4:0] mw_rd[2];
  logic       mw_we[2];
  logic       stall_o[2];
  logic       wen_o  [2];
  logic       sten_o [2];
  logic       bypa_o [2];
  logic       bypb_o [2];
  logic [1:0] fa_o   [2];
  logic [1:0] fb_o   [2];

  // Program for the pipeline model.
  logic [4:0] p_rd [8];
  logic [4:0] p_ra [8];
  logic [4:0] p_rb [8];
  logic       p_ld [8];
  int         p_n;
  logic       h_stall [16];
  logic [1:0] h_fa    [16];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  hz_interlock #(.REG_AW(5), .FWD_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .dec_rs_a(rs_a[1]), .dec_rs_b(rs_b[1]), .dec_wr_en(dwe[1]), .dec_st_en(dst[1]),
    .idex_rd(ix_rd[1]), .idex_we(ix_we[1]), .idex_is_load(ix_ld[1]),
    .exmem_rd(em_rd[1]), .exmem_we(em_we[1]), .memwb_rd(mw_rd[1]), .memwb_we(mw_we[1]),
    .stall(stall_o[1]), .idex_wr_en_d(wen_o[1]), .idex_st_en_d(sten_o[1]),
    .rf_byp_a(bypa_o[1]), .rf_byp_b(bypb_o[1]), .ex_fwd_a(fa_o[1]), .ex_fwd_b(fb_o[1])
  );

  hz_interlock #(.REG_AW(5), .FWD_EN(1'b0)) dut_so (
    .clk(clk), .rst_n(rst_n),
    .dec_rs_a(rs_a[0]), .dec_rs_b(rs_b[0]), .dec_wr_en(dwe[0]), .dec_st_en(dst[0]),
    .idex_rd(ix_rd[0]), .idex_we(ix_we[0]), .idex_is_load(ix_ld[0]),
    .exmem_rd(em_rd[0]), .exmem_we(em_we[0]), .memwb_rd(mw_rd[0]), .memwb_we(mw_we[0]),
    .stall(stall_o[0]), .idex_wr_en_d(wen_o[0]), .idex_st_en_d(sten_o[0]),
    .rf_byp_a(bypa_o[0]), .rf_byp_b(bypb_o[0]), .ex_fwd_a(fa_o[0]), .ex_fwd_b(fb_o[0])
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic clear_in();
    for (int m = 0; m < 2; m++) begin
      rs_a[m] = '0; rs_b[m] = '0; dwe[m] = 1'b0; dst[m] = 1'b0;
      ix_rd[m] = '0; ix_we[m] = 1'b0; ix_ld[m] = 1'b0;
      em_rd[m] = '0; em_we[m] = 1'b0; mw_rd[m] = '0; mw_we[m] = 1'b0;
    end
  endtask

  task automatic t_reset();
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R6 reset ex_fwd_a", fa_o[m], 0);
      chk("R6 reset ex_fwd_b", fb_o[m], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_zero_reg();
    @(negedge clk);
    clear_in();
    for (int m = 0; m < 2; m++) begin
      ix_rd[m] = 5'd0; ix_we[m] = 1'b1; ix_ld[m] = 1'b1;
      em_rd[m] = 5'd0; em_we[m] = 1'b1; mw_rd[m] = 5'd0; mw_we[m] = 1'b1;
    end
    #1;
    for (int m = 0; m < 2; m++) begin
      chk("R1 r0 source stall", stall_o[m], 0);
      chk("R1 r0 source bypass", bypa_o[m], 0);
    end
  endtask

  task automatic t_we_gate();
    @(negedge clk);
    clear_in();
    for (int m = 0; m < 2; m++) begin
      rs_a[m] = 5'd7; rs_b[m] = 5'd7;
      ix_rd[m] = 5'd7; ix_ld[m] = 1'b1; em_rd[m] = 5'd7; mw_rd[m] = 5'd7;
    end
    #1;
    for (int m = 0; m < 2; m++) begin
      chk("R2 disabled stages stall", stall_o[m], 0);
      chk("R2 disabled stages bypass", bypb_o[m], 0);
    end
  endtask

  task automatic t_lock_each_stage();
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      clear_in();
      rs_b[0] = 5'd9; rs_a[0] = 5'd4;
      if (s == 0) begin ix_rd[0] = 5'd9; ix_we[0] = 1'b1; end
      if (s == 1) begin em_rd[0] = 5'd9; em_we[0] = 1'b1; end
      if (s == 2) begin mw_rd[0] = 5'd9; mw_we[0] = 1'b1; end
      #1;
      chk($sformatf("R3 interlock stage %0d", s), stall_o[0], 1);
    end
    @(negedge clk);
    clear_in();
    rs_a[0] = 5'd4; rs_b[0] = 5'd5; ix_rd[0] = 5'd6; ix_we[0] = 1'b1;
    #1;
    chk("R3 interlock no match", stall_o[0], 0);
  endtask

  task automatic t_load_use();
    @(negedge clk);
    clear_in();
    rs_a[1] = 5'd8; ix_rd[1] = 5'd8; ix_we[1] = 1'b1;
    #1;
    chk("R4 non-load producer no stall", stall_o[1], 0);
    ix_ld[1] = 1'b1;
    #1;
    chk("R4 load-use stall", stall_o[1], 1);
    ix_rd[1] = 5'd3;
    #1;
    chk("R4 load other reg no stall", stall_o[1], 0);
    clear_in();
    rs_b[1] = 5'd8; em_rd[1] = 5'd8; em_we[1] = 1'b1;
    #1;
    chk("R4 older producer no stall", stall_o[1], 0);
  endtask

  task automatic t_bubble();
    @(negedge clk);
    clear_in();
    dwe[0] = 1'b1; dst[0] = 1'b1;
    rs_a[0] = 5'd2; em_rd[0] = 5'd2; em_we[0] = 1'b1;
    #1;
    chk("R5 stall clears wr_en", wen_o[0], 0);
    chk("R5 stall clears st_en", sten_o[0], 0);
    em_we[0] = 1'b0;
    #1;
    chk("R5 pass wr_en", wen_o[0], 1);
    chk("R5 pass st_en", sten_o[0], 1);
  endtask

  task automatic t_rf_bypass();
    @(negedge clk);
    clear_in();
    for (int m = 0; m < 2; m++) begin
      rs_a[m] = 5'd12; rs_b[m] = 5'd13; mw_rd[m] = 5'd12; mw_we[m] = 1'b1;
    end
    #1;
    chk("R8 bypass port a", bypa_o[1], 1);
    chk("R8 bypass port b", bypb_o[1], 0);
    chk("R8 interlock-only no bypass", bypa_o[0], 0);
  endtask

  task automatic t_fwd_sel();
    @(negedge clk);
    clear_in();
    rs_a[1] = 5'd10; rs_b[1] = 5'd11;
    ix_rd[1] = 5'd10; ix_we[1] = 1'b1; em_rd[1] = 5'd11; em_we[1] = 1'b1;
    @(negedge clk);
    chk("R6 sel from ID/EX producer", fa_o[1], 1);
    chk("R6 sel from EX/MEM producer", fb_o[1], 2);
    clear_in();
    rs_a[1] = 5'd14; ix_rd[1] = 5'd14; ix_we[1] = 1'b1; em_rd[1] = 5'd14; em_we[1] = 1'b1;
    @(negedge clk);
    chk("R7 newer producer wins", fa_o[1], 1);
    clear_in();
    rs_a[1] = 5'd15; mw_rd[1] = 5'd15; mw_we[1] = 1'b1;
    @(negedge clk);
    chk("R6 MEM/WB producer uses regfile path", fa_o[1], 0);
  endtask

  // Behavioural pipeline around one variant; logs stall and ex_fwd_a.
  task automatic run_prog(input int m, output int stalls);
    int         pc = 0;
    logic [4:0] i_rd = '0, e_rd = '0, w_rd = '0;
    logic       i_we = 1'b0, i_ld = 1'b0, e_we = 1'b0, w_we = 1'b0;
    stalls = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      clear_in();
      dwe[m] = 1'b1;
      if (pc < p_n) begin
        rs_a[m] = p_ra[pc]; rs_b[m] = p_rb[pc];
      end
      ix_rd[m] = i_rd; ix_we[m] = i_we; ix_ld[m] = i_ld;
      em_rd[m] = e_rd; em_we[m] = e_we; mw_rd[m] = w_rd; mw_we[m] = w_we;
      #1;
      h_stall[c] = stall_o[m];
      h_fa[c]    = fa_o[m];
      if (stall_o[m]) stalls++;
      w_rd = e_rd; w_we = e_we;
      e_rd = i_rd; e_we = i_we;
      if (stall_o[m] || pc >= p_n) begin
        i_rd = '0; i_we = 1'b0; i_ld = 1'b0;
      end else begin
        i_rd = p_rd[pc]; i_we = 1'b1; i_ld = p_ld[pc];
      end
      if (!stall_o[m] && pc < p_n) pc++;
    end
  endtask

  task automatic t_add_sub();
    int st;
    p_n = 2;
    p_rd[0] = 5'd3; p_ra[0] = 5'd1; p_rb[0] = 5'd2; p_ld[0] = 1'b0;
    p_rd[1] = 5'd5; p_ra[1] = 5'd3; p_rb[1] = 5'd5; p_ld[1] = 1'b0;
    run_prog(0, st);
    chk("R10 interlock-only stall count", st, 3);
    chk("R10 interlock-only first stall cycle", h_stall[1], 1);
    chk("R10 interlock-only released", h_stall[4], 0);
    run_prog(1, st);
    chk("R10 forwarding stall count", st, 0);
    chk("R10 forwarding sub operand a", h_fa[2], 1);
  endtask

  task automatic t_load_seq();
    int st;
    p_n = 2;
    p_rd[0] = 5'd4; p_ra[0] = 5'd1; p_rb[0] = 5'd0; p_ld[0] = 1'b1;
    p_rd[1] = 5'd6; p_ra[1] = 5'd4; p_rb[1] = 5'd1; p_ld[1] = 1'b0;
    run_prog(1, st);
    chk("R4 load-use single stall", st, 1);
    chk("R4 stall in dependent cycle", h_stall[1], 1);
    chk("R9 bubble sel after stall", h_fa[2], 0);
    chk("R6 load result from MEM/WB", h_fa[3], 2);
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    t_reset();
    t_zero_reg();
    t_we_gate();
    t_lock_each_stage();
    t_load_use();
    t_bubble();
    t_rf_bypass();
    t_fwd_sel();
    t_add_sub();
    t_load_seq();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule